// File: doc/BRIEF.md
# Serial Management Register Target

This block is the target side of a two-wire management link. It has one clock line and one bidirectional data line, and the data line is split into an input, an output and an output enable for an external tri-state pad. The block watches the line for a management frame with standard MDIO framing. It uses that frame to read or write a bank of 142 eight-bit configuration registers, and it owns that bank.

Three things differ from ordinary clause-22 access:
- The opcode field must be zero.
- The transfer direction comes from the top bit of the five-bit PHY-address field.
- The eight-bit register address is built from the three low PHY-address bits followed by the five register-address bits.

Only the low byte of the sixteen-bit data field is used.

A second, synchronous port gives on-chip logic direct access to the same registers. It has an address, write data, a write strobe and registered read data. Both ports run on the management clock.

Top module: `mgmt_reg_target`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits followed by the start pattern 0 then 1. If the run of 1s is shorter, the frame is ignored: nothing is written and the pad is never driven.
- R2: The two opcode bits that follow the start pattern must both be 0. Any other opcode makes the target ignore the rest of the frame and go back to hunting for a new preamble.
- R3: The fifth header field bit (PHY-address bit 4) selects the direction: 1 is a read and 0 is a write. PHY-address bit 3 has no effect. During a write frame the output enable stays low.
- R4: The register address is {PHY-address bits [2:0], register-address bits [4:0]}, with the PHY bits in the most significant positions. All fields are sent most significant bit first.
- R5: On a read, the output enable is low for the first turnaround bit time. It is then high, driving 0, for the second turnaround bit time. It stays high for the 16 data bit times and then drops.
- R6: Read data is sent MSB first as 16 bits: eight 0 bits, then the 8-bit register value.
- R7: On a write, the target ignores the upper 8 data bits after the two turnaround bits. It stores the lower 8 bits into the addressed register at the clock edge that samples the last data bit.
- R8: Addresses 0x00 to 0x8D exist. A read of a higher address returns 0 on either port. A write to a higher address changes nothing.
- R9: On the local port, a write strobe stores the write data at the clock edge. Read data is registered: it shows the value at the presented address one clock later. If both ports write the same register in the same cycle, the serial write takes effect.
- R10: A synchronous active-low reset clears every register to 0 and puts the line in the released state.
- R11: After any completed or rejected frame, a new frame again needs a full preamble. A frame that follows directly without a preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mdio_i | input | 1 | Data line as seen from the pad |
| mdio_o | output | 1 | Data value driven onto the line when enabled |
| mdio_oe | output | 1 | Output enable for the tri-state pad |
| loc_addr | input | 8 | Local port register address |
| loc_wdata | input | 8 | Local port write data |
| loc_we | input | 1 | Local port write strobe |
| loc_rdata | output | 8 | Local port read data, registered |

## Verification
The assertions run on every cycle. They check the following:
- the first driven turnaround bit is 0;
- the upper read byte is never 1;
- the pad is never enabled while a serial write lands;
- a rejected opcode releases the line;
- a serial write reaches the addressed register;
- out-of-range local reads return 0.

Some behaviours depend on the whole frame and on the bank's contents over time, so only the bench's scenarios can show them. These are:
- the address mapping over all 256 addresses;
- that bit 3 has no effect;
- rejection of short preambles, bad start patterns and back-to-back frames;
- the agreement between serial and local views of each register.

// File: rtl/mgmt_pkg.sv
// Package: shared constants and the frame state type for the serial
// management register target. Assumes the fixed frame layout: 12 header
// bits after the start pattern, 2 turnaround bits, 16 data bits.
package mgmt_pkg;

    localparam int HDR_BITS   = 12;
    localparam int FIELD_BITS = 16;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = $clog2(FIELD_BITS);

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SOF,
        ST_HDR,
        ST_RTA_Z,
        ST_RTA_0,
        ST_RDATA,
        ST_WTA,
        ST_WDATA
    } frame_st_t;

endpackage

// File: rtl/mgmt_frame_fsm.sv
// Module: frame sequencer. Counts the preamble, checks the start pattern,
// shifts in the header, then either serialises read data or gathers write
// data. Assumes inputs are sampled on the rising clock edge and outputs
// change just after it, so they are stable for the controller's next sample.
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] ser_addr,
    output logic              ser_we,
    output logic [DATA_W-1:0] ser_wdata,
    input  logic [DATA_W-1:0] ser_rdata
);

    localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PREAMBLE_LEN);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FIELD_BITS - 1);

    frame_st_t              state;
    logic [PRE_W-1:0]       pre_cnt;
    logic [CNT_W-1:0]       bit_cnt;
    logic [HDR_BITS-1:0]    hdr_q;
    logic [HDR_BITS-1:0]    hdr_full;
    logic [FIELD_BITS-1:0]  shreg;
    logic [ADDR_W-1:0]      addr_q;

    // Header word including the bit being sampled this cycle.
    assign hdr_full = {hdr_q[HDR_BITS-2:0], mdio_i};

    // Frame sequencing, counters and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            pre_cnt <= '0;
            bit_cnt <= '0;
            hdr_q   <= '0;
            shreg   <= '0;
            addr_q  <= '0;
        end else begin
            case (state)
                ST_HUNT: begin
                    if (mdio_i) begin
                        if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
                    end else begin
                        pre_cnt <= '0;
                        if (pre_cnt == PRE_MAX) state <= ST_SOF;
                    end
                end
                ST_SOF: begin
                    if (mdio_i) begin
                        state   <= ST_HDR;
                        bit_cnt <= HDR_LAST;
                    end else begin
                        state <= ST_HUNT;
                    end
                end
                ST_HDR: begin
                    hdr_q <= hdr_full;
                    if (bit_cnt == '0) begin
                        addr_q <= hdr_full[ADDR_W-1:0];
                        if (hdr_full[11:10] != 2'b00) begin
                            state <= ST_HUNT;
                        end else if (hdr_full[9]) begin
                            state <= ST_RTA_Z;
                        end else begin
                            state   <= ST_WTA;
                            bit_cnt <= CNT_W'(1);
                        end
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                ST_RTA_Z: begin
                    shreg <= {{(FIELD_BITS-DATA_W){1'b0}}, ser_rdata};
                    state <= ST_RTA_0;
                end
                ST_RTA_0: begin
                    state   <= ST_RDATA;
                    bit_cnt <= DATA_LAST;
                end
                ST_RDATA: begin
                    shreg <= {shreg[FIELD_BITS-2:0], 1'b0};
                    if (bit_cnt == '0) state <= ST_HUNT;
                    else               bit_cnt <= bit_cnt - 1'b1;
                end
                ST_WTA: begin
                    if (bit_cnt == '0) begin
                        state   <= ST_WDATA;
                        bit_cnt <= DATA_LAST;
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                ST_WDATA: begin
                    shreg <= {shreg[FIELD_BITS-2:0], mdio_i};
                    if (bit_cnt == '0) state <= ST_HUNT;
                    else               bit_cnt <= bit_cnt - 1'b1;
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Register-side access and pad control.
    always_comb begin
        ser_addr  = addr_q;
        ser_we    = (state == ST_WDATA) && (bit_cnt == '0);
        ser_wdata = {shreg[DATA_W-2:0], mdio_i};
        mdio_oe   = (state == ST_RTA_0) || (state == ST_RDATA);
        mdio_o    = (state == ST_RDATA) ? shreg[FIELD_BITS-1] : 1'b0;
    end

    // R5: the first bit driven after release is the turnaround 0.
    p_ta_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R6: the upper data byte of a read is all zeros.
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && bit_cnt > CNT_W'(DATA_W - 1)) |-> !mdio_o);

    // R3: a write frame never drives the pad.
    p_no_drive_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_we |-> !mdio_oe);

    // R2: a nonzero opcode returns to hunting with the line released.
    p_bad_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && bit_cnt == '0 && hdr_full[11:10] != 2'b00)
        |=> (!mdio_oe && state == ST_HUNT));

    // R10: reset releases the line.
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> !mdio_oe);

endmodule

// File: rtl/mgmt_reg_bank.sv
// Module: configuration register bank. Holds NUM_REGS eight-bit registers
// with one combinational read and one write port for the serial side and a
// registered read plus write port for local logic. Assumes both ports share
// one clock; the serial write wins a same-register collision.
module mgmt_reg_bank
    import mgmt_pkg::*;
#(
    parameter int NUM_REGS = 142
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_we,
    input  logic [ADDR_W-1:0] ser_addr,
    input  logic [DATA_W-1:0] ser_wdata,
    output logic [DATA_W-1:0] ser_rdata,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    logic [DATA_W-1:0] regs [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [DATA_W-1:0] q;
            // One register: serial write first, then local write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (ser_we && ser_addr == ADDR_W'(i))
                    q <= ser_wdata;
                else if (loc_we && loc_addr == ADDR_W'(i))
                    q <= loc_wdata;
            end
            assign regs[i] = q;
        end
    endgenerate

    // Serial read: zero for addresses beyond the bank.
    always_comb begin
        ser_rdata = (ser_addr <= LAST_ADDR) ? regs[ser_addr] : '0;
    end

    // Local read: registered, zero beyond the bank.
    always_ff @(posedge clk) begin
        if (!rst_n)
            loc_rdata <= '0;
        else
            loc_rdata <= (loc_addr <= LAST_ADDR) ? regs[loc_addr] : '0;
    end

    // R7: a serial write lands in the addressed register.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_we && ser_addr <= LAST_ADDR)
        |=> (regs[$past(ser_addr)] == $past(ser_wdata)));

    // R8: local reads above the bank return zero.
    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr > LAST_ADDR) |=> (loc_rdata == '0));

endmodule

// File: rtl/mgmt_reg_target.sv
// Module: top of the serial management register target. Connects the frame
// sequencer to the register bank and exposes the pad and local ports.
// Assumes the pad's tri-state buffer is outside this block.
module mgmt_reg_target
    import mgmt_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32,
    parameter int NUM_REGS     = 142
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic [7:0]  loc_addr,
    input  logic [7:0]  loc_wdata,
    input  logic        loc_we,
    output logic [7:0]  loc_rdata
);

    logic [ADDR_W-1:0] ser_addr;
    logic              ser_we;
    logic [DATA_W-1:0] ser_wdata;
    logic [DATA_W-1:0] ser_rdata;

    mgmt_frame_fsm #(
        .PREAMBLE_LEN (PREAMBLE_LEN)
    ) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .ser_addr  (ser_addr),
        .ser_we    (ser_we),
        .ser_wdata (ser_wdata),
        .ser_rdata (ser_rdata)
    );

    mgmt_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk       (mdc),
        .rst_n     (rst_n),
        .ser_we    (ser_we),
        .ser_addr  (ser_addr),
        .ser_wdata (ser_wdata),
        .ser_rdata (ser_rdata),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: tb/test_mgmt_reg_target.sv
`timescale 1ns/1ps
module test_mgmt_reg_target;

    logic       mdc = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdio_i = 1'b0;
    logic       mdio_o;
    logic       mdio_oe;
    logic [7:0] loc_addr = 8'h00;
    logic [7:0] loc_wdata = 8'h00;
    logic       loc_we = 1'b0;
    logic [7:0] loc_rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;
    bit  oe_seen  = 0;

    mgmt_reg_target i_mgmt_reg_target (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_we    (loc_we),
        .loc_rdata (loc_rdata)
    );

    always #10 mdc = ~mdc;

    // Record any pad drive, sampled away from the active edge.
    always @(negedge mdc) if (mdio_oe === 1'b1) oe_seen = 1;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) ^ 8'hA5);
    endfunction

    function automatic logic [7:0] stored(int a);
        return (a < 142) ? pat(a) : 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_bit(logic b);
        @(negedge mdc);
        mdio_i = b;
        @(posedge mdc);
    endtask

    task automatic send_header(int pre, logic [1:0] sof, logic [1:0] op,
                               logic rw, logic b3, logic [7:0] addr);
        drive_bit(1'b0);
        drive_bit(1'b0);
        for (int i = 0; i < pre; i++) drive_bit(1'b1);
        drive_bit(sof[1]); drive_bit(sof[0]);
        drive_bit(op[1]);  drive_bit(op[0]);
        drive_bit(rw);     drive_bit(b3);
        for (int i = 7; i >= 0; i--) drive_bit(addr[i]);
    endtask

    task automatic ser_write(int pre, logic [1:0] sof, logic [1:0] op,
                             logic b3, logic [7:0] addr, logic [15:0] d);
        oe_seen = 0;
        send_header(pre, sof, op, 1'b0, b3, addr);
        drive_bit(1'b1);
        drive_bit(1'b0);
        for (int i = 15; i >= 0; i--) drive_bit(d[i]);
    endtask

    task automatic ser_read(logic b3, logic [7:0] addr, logic [15:0] exp);
        logic [15:0] got;
        logic        ta_ok;
        logic        oe_ok;
        send_header(32, 2'b01, 2'b00, 1'b1, b3, addr);
        @(negedge mdc);
        mdio_i = 1'b1;
        ta_ok = (mdio_oe === 1'b0);
        @(posedge mdc);
        @(negedge mdc);
        ta_ok = ta_ok && (mdio_oe === 1'b1) && (mdio_o === 1'b0);
        @(posedge mdc);
        oe_ok = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            got[i] = mdio_o;
            oe_ok = oe_ok && (mdio_oe === 1'b1);
            @(posedge mdc);
        end
        @(negedge mdc);
        oe_ok = oe_ok && (mdio_oe === 1'b0);
        check("R5 turnaround", {31'd0, ta_ok}, 32'd1);
        check("R5 enable window", {31'd0, oe_ok}, 32'd1);
        check("R6/R4/R8 read data", {16'd0, got}, {16'd0, exp});
    endtask

    task automatic loc_read(logic [7:0] a, output logic [7:0] v);
        @(negedge mdc);
        loc_addr = a;
        @(posedge mdc);
        @(negedge mdc);
        v = loc_rdata;
    endtask

    task automatic loc_write(logic [7:0] a, logic [7:0] d);
        @(negedge mdc);
        loc_addr = a; loc_wdata = d; loc_we = 1'b1;
        @(posedge mdc);
        @(negedge mdc);
        loc_we = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(150000 * 20);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge mdc);
        @(negedge mdc);
        check("R10 line released in reset", {31'd0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 142; a += 13) begin
            loc_read(8'(a), v);
            check("R10 cleared", {24'd0, v}, 32'd0);
        end

        // Write sweep over all 256 addresses; bit 3 toggled, upper byte junk.
        for (int a = 0; a < 256; a++) begin
            ser_write(32, 2'b01, 2'b00, 1'(a >> 1), 8'(a), {~8'(a), pat(a)});
            check("R3 no drive on write", {31'd0, oe_seen}, 32'd0);
        end
        // Read sweep with the opposite bit-3 pattern.
        for (int a = 0; a < 256; a++)
            ser_read(1'(a), 8'(a), {8'h00, stored(a)});
        // Local reads see the same linear address map (R9, R4, R7, R8).
        for (int a = 0; a < 256; a++) begin
            loc_read(8'(a), v);
            check("R9 local read", {24'd0, v}, {24'd0, stored(a)});
        end

        // R9: local write visible to serial read; R8: local write beyond bank.
        loc_write(8'h20, 8'h3C);
        ser_read(1'b0, 8'h20, 16'h003C);
        loc_write(8'd200, 8'h77);
        loc_read(8'd200, v);
        check("R8 local write beyond bank", {24'd0, v}, 32'd0);

        // R1: 31-bit preamble ignored.
        ser_write(31, 2'b01, 2'b00, 1'b0, 8'h05, 16'h00EE);
        check("R1 short preamble no drive", {31'd0, oe_seen}, 32'd0);
        ser_read(1'b0, 8'h05, {8'h00, pat(5)});
        // R1: bad start pattern ignored.
        ser_write(32, 2'b00, 2'b00, 1'b0, 8'h05, 16'h00EE);
        ser_read(1'b0, 8'h05, {8'h00, pat(5)});

        // R2: nonzero opcodes ignored.
        ser_write(32, 2'b01, 2'b01, 1'b0, 8'h06, 16'h0011);
        ser_write(32, 2'b01, 2'b11, 1'b0, 8'h06, 16'h0011);
        ser_read(1'b0, 8'h06, {8'h00, pat(6)});
        oe_seen = 0;
        send_header(32, 2'b01, 2'b10, 1'b1, 1'b0, 8'h06);
        repeat (20) drive_bit(1'b0);
        check("R2 bad opcode read no drive", {31'd0, oe_seen}, 32'd0);

        // R11: a frame right after another, without a preamble, is ignored.
        ser_write(32, 2'b01, 2'b00, 1'b0, 8'h07, 16'h0011);
        ser_write(0, 2'b01, 2'b00, 1'b0, 8'h08, 16'h0022);
        ser_read(1'b0, 8'h07, 16'h0011);
        ser_read(1'b0, 8'h08, {8'h00, pat(8)});

        // R10: reset clears the bank.
        @(negedge mdc);
        rst_n = 1'b0;
        repeat (2) @(posedge mdc);
        @(negedge mdc);
        rst_n = 1'b1;
        loc_read(8'h07, v);
        check("R10 reset clears", {24'd0, v}, 32'd0);

        finished = 1;
        report();
    end

endmodule